// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous static RAM. The bus never needs an idle cycle when it turns from read to write or back. Every command is registered on the rising clock edge. For a read, the data leaves the output register two enabled clock edges after the command was loaded. For a write, the data is taken from the data bus at the same second enabled edge, so reads and writes share one pipeline slot and may alternate every cycle.

A load cycle brings in a new address and command: read, write or deselect. An advance cycle steps an internal 2-bit burst counter and keeps the command type of the last load. The burst counter can follow a linear order or an interleaved order. An active-low clock enable freezes the whole pipeline.

Accepted write data waits in a one-entry write buffer before it reaches the array. A read that hits that buffer receives the buffered lanes merged over the array contents. The shared data bus is modelled as split input and output vectors plus a drive-enable output, which a pad or the surrounding logic turns into the physical bus.

Top module: `nws_sram`

## Requirements
- R1: After a synchronous reset (`rst_n` low at an edge) the output register `dq_o` is zero and `dq_oe` is low until a read reaches its data slot.
- R2: A read loaded at enabled edge n drives the stored word on `dq_o` with `dq_oe` high after enabled edge n+2, while `oe_n` is low.
- R3: A write loaded at enabled edge n takes its data from `dq_i` at enabled edge n+2, and `dq_oe` is low in that slot. Reads and writes may alternate on consecutive cycles with no idle cycle.
- R4: Lane i of the word is bits [9i+8:9i] (8 data bits and a parity bit). A write updates lane i only when `bw_n[i]` is low during its address cycle; other lanes keep their old contents.
- R5: The chip is selected only when `ce_n`=0, `ce2`=1 and `ce2_n`=0 on a load cycle. Otherwise the loaded command is a deselect: nothing is written and `dq_oe` stays low in its slot. The enables are not sampled on advance cycles.
- R6: With `adv`=1 the burst counter steps and the command type of the last load continues, whatever `addr` and `rw_n` carry. With the order latched low at load, the low two address bits of beat k are (start + k) mod 4, and the upper address bits stay fixed.
- R7: With `burst_ilv`=1 at load, the low two address bits of beat k are start XOR k.
- R8: While `cke_n` is high, all synchronous inputs are ignored and every register holds, including the driven output word and any partly done burst.
- R9: A read whose slot directly follows a write slot to the same address returns the newly written lanes merged over the old ones.
- R10: `oe_n` high forces `dq_oe` low at once, with no clock edge needed. Lowering it again restores the drive of a held read word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low; high freezes the pipeline |
| ce_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 = advance burst, 0 = load new address and command |
| rw_n | input | 1 | 1 = read, 0 = write (on load cycles) |
| bw_n | input | LANES | Per-lane write enables, active low |
| burst_ilv | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_i | input | LANES*LANE_W | Data bus as seen at the pins (write data) |
| dq_o | output | LANES*LANE_W | Read data output register |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
A scoreboard drives random traffic against a reference memory. The traffic mixes loads, advances, deselects, partial-lane writes and clock-enable stalls inserted mid-burst, under both burst orders. Separate checks tell apart a wrong pipeline depth (R2, R3), a wrong beat order (R6, R7) and lost lanes (R4). Reads issued right after a write to the same address show whether write-buffer forwarding (R9) is present, since a missing merge returns stale words. A directed stall holding a read word on the bus, with `oe_n` toggled during the stall, separates the hold behaviour (R8) from the asynchronous output gate (R10).

// File: rtl/nws_pkg.sv
// Shared types and helpers for the zero-turnaround SRAM model.
// Assumes a 2-bit burst counter (bursts of four words).
package nws_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_e;

    // Low address bits of a burst beat for the chosen order.
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] beat,
                                               input logic       ilv);
        return ilv ? (start ^ beat) : 2'(start + beat);
    endfunction

endpackage

// File: rtl/nws_ctrl.sv
// Address and command stage: decodes chip select and read/write on load
// cycles, steps the burst counter on advance cycles and registers the
// effective address, command and lane mask into pipeline stage 1.
// Assumes ADDR_W >= 3; everything holds while en is low.
module nws_ctrl
    import nws_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce2_n,
    input  logic              adv,
    input  logic              rw_n,
    input  logic              burst_ilv,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              cmd1,
    output logic [ADDR_W-1:0] addr1,
    output logic [LANES-1:0]  wmask1
);

    localparam int HI_W = ADDR_W - 2;

    cmd_e            run_cmd;
    cmd_e            load_cmd;
    logic [HI_W-1:0] base_q;
    logic [1:0]      start_q;
    logic [1:0]      beat_q;
    logic [1:0]      beat_nx;
    logic            ilv_q;
    logic            sel;

    // Decode the command a load cycle would start.
    always_comb begin
        sel      = !ce_n && ce2 && !ce2_n;
        load_cmd = !sel ? CMD_IDLE : (rw_n ? CMD_RD : CMD_WR);
        beat_nx  = beat_q + 2'd1;
    end

    // Burst bookkeeping: latch the start point on load, step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cmd <= CMD_IDLE;
            base_q  <= '0;
            start_q <= '0;
            beat_q  <= '0;
            ilv_q   <= 1'b0;
        end else if (en) begin
            if (!adv) begin
                run_cmd <= load_cmd;
                base_q  <= addr[ADDR_W-1:2];
                start_q <= addr[1:0];
                beat_q  <= 2'd0;
                ilv_q   <= burst_ilv;
            end else begin
                beat_q  <= beat_nx;
            end
        end
    end

    // Stage 1 register: command, effective address and lane mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd1   <= CMD_IDLE;
            addr1  <= '0;
            wmask1 <= '0;
        end else if (en) begin
            wmask1 <= ~bw_n;
            if (!adv) begin
                cmd1  <= load_cmd;
                addr1 <= addr;
            end else begin
                cmd1  <= run_cmd;
                addr1 <= {base_q, beat_offset(start_q, beat_nx, ilv_q)};
            end
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(addr1) && $stable(cmd1) && $stable(wmask1)); // R8
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        en && adv |=> $stable(addr1[ADDR_W-1:2])); // R6
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        en && adv && !ilv_q |=> addr1[1:0] == 2'($past(addr1[1:0]) + 2'd1)); // R6
    AST_ILV_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        en && adv && ilv_q |=> addr1[0] != $past(addr1[0])); // R7

endmodule

// File: rtl/nws_store.sv
// Storage: register array plus a one-entry write buffer. Accepted write
// data is parked in the buffer and committed on the next enabled edge;
// the read port merges buffered lanes over the array word on an address hit.
// Assumes at most one access (read or write) per enabled edge.
module nws_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANES-1:0]         wmask,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int DW    = LANES * LANE_W;

    logic [DW-1:0]     mem [DEPTH];
    logic              wb_vld;
    logic [ADDR_W-1:0] wb_addr;
    logic [LANES-1:0]  wb_mask;
    logic [DW-1:0]     wb_data;
    logic              hit;

    // Commit the parked write, lane by lane.
    always_ff @(posedge clk) begin
        if (en && wb_vld) begin
            for (int l = 0; l < LANES; l++) begin
                if (wb_mask[l]) begin
                    mem[wb_addr][l*LANE_W +: LANE_W] <= wb_data[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Park newly accepted write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_vld  <= 1'b0;
            wb_addr <= '0;
            wb_mask <= '0;
            wb_data <= '0;
        end else if (en) begin
            wb_vld <= wr;
            if (wr) begin
                wb_addr <= waddr;
                wb_mask <= wmask;
                wb_data <= wdata;
            end
        end
    end

    // Detect a read of the parked address.
    always_comb hit = wb_vld && (wb_addr == raddr);

    // Per-lane forwarding mux.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdata[g*LANE_W +: LANE_W] = (hit && wb_mask[g])
            ? wb_data[g*LANE_W +: LANE_W]
            : mem[raddr][g*LANE_W +: LANE_W];
    end

    AST_WB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en && wr |=> wb_vld && wb_addr == $past(waddr) && wb_data == $past(wdata)); // R3
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(wb_vld) && $stable(wb_data)); // R8
    AST_FWD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        hit && (&wb_mask) |-> rdata == wb_data); // R9

endmodule

// File: rtl/nws_sram.sv
// Top of the zero-turnaround SRAM model. Stage 1 comes from nws_ctrl;
// stage 2 carries the slot in which write data is taken from dq_i or
// read data is loaded into the output register. oe_n gates the drive
// enable without a clock. Assumes a single clock domain.
module nws_sram
    import nws_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    ce_n,
    input  logic                    ce2,
    input  logic                    ce2_n,
    input  logic                    adv,
    input  logic                    rw_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    burst_ilv,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe
);

    localparam int DW = LANES * LANE_W;

    logic              en;
    cmd_e              cmd1;
    cmd_e              cmd2;
    logic [ADDR_W-1:0] addr1;
    logic [ADDR_W-1:0] addr2;
    logic [LANES-1:0]  wmask1;
    logic [LANES-1:0]  wmask2;
    logic [DW-1:0]     rdata;
    logic [DW-1:0]     dq_q;
    logic              drv_q;
    logic              wr2;

    // Clock-enable polarity and write strobe for the data slot.
    always_comb begin
        en  = !cke_n;
        wr2 = (cmd2 == CMD_WR);
    end

    nws_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ce_n      (ce_n),
        .ce2       (ce2),
        .ce2_n     (ce2_n),
        .adv       (adv),
        .rw_n      (rw_n),
        .burst_ilv (burst_ilv),
        .bw_n      (bw_n),
        .addr      (addr),
        .cmd1      (cmd1),
        .addr1     (addr1),
        .wmask1    (wmask1)
    );

    // Stage 2 register: the slot one edge before data moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd2   <= CMD_IDLE;
            addr2  <= '0;
            wmask2 <= '0;
        end else if (en) begin
            cmd2   <= cmd1;
            addr2  <= addr1;
            wmask2 <= wmask1;
        end
    end

    nws_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .wr    (wr2),
        .waddr (addr2),
        .wmask (wmask2),
        .wdata (dq_i),
        .raddr (addr2),
        .rdata (rdata)
    );

    // Output register and its drive flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_q  <= '0;
            drv_q <= 1'b0;
        end else if (en) begin
            drv_q <= (cmd2 == CMD_RD);
            if (cmd2 == CMD_RD) begin
                dq_q <= rdata;
            end
        end
    end

    assign dq_o  = dq_q;
    assign dq_oe = drv_q && !oe_n;

    AST_SLOT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        en && cmd2 != CMD_RD |=> !dq_oe); // R5
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        en && cmd2 == CMD_RD |=> dq_oe || oe_n); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dq_o) && $stable(drv_q)); // R8

endmodule

// File: tb/sim_nws_sram.sv
module sim_nws_sram;

    localparam int AW = 6;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n, cke_n, ce_n, ce2, ce2_n, adv, rw_n, burst_ilv, oe_n;
    logic [1:0]    bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_i, dq_o;
    logic          dq_oe;

    always #10 clk = ~clk;

    nws_sram u0 (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce_n(ce_n), .ce2(ce2),
        .ce2_n(ce2_n), .adv(adv), .rw_n(rw_n), .bw_n(bw_n),
        .burst_ilv(burst_ilv), .oe_n(oe_n), .addr(addr), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    typedef struct {
        int            kind;   // 0 idle, 1 read, 2 write
        logic [AW-1:0] a;
        logic [1:0]    mask;
        logic [DW-1:0] data;
        int            due;
        int            tag;    // 2 plain, 6 linear beat, 7 interleaved beat
    } item_t;

    item_t         q[$];
    logic [DW-1:0] refm [64];
    bit            part [64];
    int            en_cnt = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 0;
    int            last_wr_due = -10;
    logic [AW-1:0] last_wr_a = '0;

    // bench burst model
    int            m_kind = 0;
    logic [AW-3:0] m_base = '0;
    logic [1:0]    m_start = '0, m_cnt = '0;
    bit            m_ilv = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_name(input int t);
        case (t)
            6: return "R6";
            7: return "R7";
            9: return "R9";
            4: return "R4";
            default: return "R2";
        endcase
    endfunction

    always @(posedge clk) if (!cke_n) en_cnt++;

    // Monitor: pop slots whose data edge has passed, then present write data.
    always @(negedge clk) begin
        bit found;
        while (q.size() > 0 && q[0].due <= en_cnt) begin
            item_t it;
            it = q.pop_front();
            if (it.kind == 1) begin
                int t;
                t = it.tag;
                if (last_wr_due == it.due - 1 && last_wr_a == it.a) t = 9;
                else if (part[it.a]) t = 4;
                chk(dq_oe && dq_o == refm[it.a], tag_name(t), dq_o, refm[it.a]);
            end else if (it.kind == 2) begin
                chk(!dq_oe, "R3 write slot not driven", {17'b0, dq_oe}, '0);
                for (int l = 0; l < 2; l++)
                    if (it.mask[l]) refm[it.a][l*9 +: 9] = it.data[l*9 +: 9];
                part[it.a] = (it.mask != 2'b11);
                last_wr_due = it.due;
                last_wr_a = it.a;
            end else begin
                chk(!dq_oe, "R5 deselect slot not driven", {17'b0, dq_oe}, '0);
            end
        end
        found = 0;
        foreach (q[i]) begin
            if (q[i].kind == 2 && q[i].due == en_cnt + 1) begin
                dq_i = q[i].data;
                found = 1;
            end
        end
        if (!found) dq_i = DW'($urandom);
    end

    // Driver: one enabled cycle with the scoreboard item it produces.
    task automatic drive(input bit ld, input bit wr, input bit sel,
                         input logic [AW-1:0] a, input logic [1:0] bwn, input bit ilv);
        item_t it;
        logic [AW-1:0] eff;
        int drop;
        @(negedge clk); #2;
        cke_n = 0; adv = !ld; bw_n = bwn; burst_ilv = ilv;
        if (ld) begin
            addr = a; rw_n = !wr;
            ce_n = 0; ce2 = 1; ce2_n = 0;
            if (!sel) begin
                drop = $urandom % 3;
                if (drop == 0) ce_n = 1; else if (drop == 1) ce2 = 0; else ce2_n = 1;
            end
            m_kind = !sel ? 0 : (wr ? 2 : 1);
            m_base = a[AW-1:2]; m_start = a[1:0]; m_cnt = 0; m_ilv = ilv;
            eff = a;
            it.tag = 2;
        end else begin
            addr = AW'($urandom); rw_n = $urandom % 2;
            ce_n = $urandom % 2; ce2 = $urandom % 2; ce2_n = $urandom % 2;
            m_cnt = m_cnt + 2'd1;
            eff = {m_base, m_ilv ? (m_start ^ m_cnt) : 2'(m_start + m_cnt)};
            it.tag = m_ilv ? 7 : 6;
        end
        it.kind = m_kind; it.a = eff; it.mask = ~bwn;
        it.data = DW'($urandom); it.due = en_cnt + 3;
        q.push_back(it);
    endtask

    // Stalled cycle with junk on every other input.
    task automatic stall();
        @(negedge clk); #2;
        cke_n = 1; adv = $urandom % 2; rw_n = $urandom % 2;
        addr = AW'($urandom); bw_n = 2'($urandom);
        ce_n = $urandom % 2; ce2 = $urandom % 2; ce2_n = $urandom % 2;
        burst_ilv = $urandom % 2;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [AW-1:0] ha;
        rst_n = 0; cke_n = 0; ce_n = 1; ce2 = 0; ce2_n = 1; adv = 0; rw_n = 1;
        bw_n = 2'b11; burst_ilv = 0; oe_n = 0; addr = '0; dq_i = '0;
        foreach (part[i]) part[i] = 0;
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        @(negedge clk); #4;
        chk(!dq_oe, "R1 no drive after reset", {17'b0, dq_oe}, '0);
        chk(dq_o == '0, "R1 output register cleared", dq_o, '0);
        @(negedge clk); #4;
        chk(!dq_oe, "R1 still idle", {17'b0, dq_oe}, '0);

        // fill every word with linear write bursts (R6 advance continues writes)
        for (int b = 0; b < 16; b++) begin
            drive(1, 1, 1, AW'(b * 4), 2'b00, 0);
            for (int k = 0; k < 3; k++) drive(0, 0, 0, '0, 2'b00, 0);
        end

        // R3/R9: alternate write and read of the same word, no idle cycle
        drive(1, 1, 1, 6'd9, 2'b10, 0);
        drive(1, 0, 1, 6'd9, 2'b11, 0);
        drive(1, 1, 1, 6'd20, 2'b00, 0);
        drive(1, 0, 1, 6'd20, 2'b11, 0);
        // R5: deselected write must leave word 30 unchanged
        drive(1, 1, 0, 6'd30, 2'b00, 0);
        drive(1, 0, 1, 6'd30, 2'b11, 0);
        // R6: linear read burst from offset 3; R7: interleaved from offset 2
        drive(1, 0, 1, 6'd7, 2'b11, 0);
        for (int k = 0; k < 3; k++) drive(0, 0, 0, '0, 2'b11, 0);
        drive(1, 0, 1, 6'd38, 2'b11, 1);
        for (int k = 0; k < 3; k++) drive(0, 0, 0, '0, 2'b11, 1);

        // R8/R10: hold a read word under stall, toggle oe_n
        drive(1, 0, 1, 6'd12, 2'b11, 0);
        drive(1, 0, 0, 6'd0, 2'b11, 0);
        drive(1, 0, 0, 6'd0, 2'b11, 0);
        stall();
        stall();
        stall();
        #3;
        chk(dq_oe && dq_o == refm[12], "R8 held read word", dq_o, refm[12]);
        oe_n = 1; #1;
        chk(!dq_oe, "R10 oe_n high releases bus", {17'b0, dq_oe}, '0);
        oe_n = 0; #1;
        chk(dq_oe && dq_o == refm[12], "R10 oe_n low drives again", dq_o, refm[12]);

        // random mixed traffic with mid-burst stalls
        for (int n = 0; n < 700; n++) begin
            int r;
            r = $urandom % 100;
            if (r < 10) begin
                stall();
            end else begin
                bit ld;
                ld = (r < 60) || (n == 0);
                ha = AW'($urandom);
                drive(ld, $urandom % 2, ($urandom % 8) != 0, ha,
                      ($urandom % 2) ? 2'b00 : 2'($urandom), $urandom % 2);
            end
        end

        for (int k = 0; k < 4; k++) drive(1, 0, 0, '0, 2'b11, 0);
        while (q.size() > 0) @(negedge clk);
        #1;
        done = 1;
        finish_run();
    end

endmodule